// File: doc/BRIEF.md
# Next-PC Selection Unit

This block holds the 32-bit program counter of a simple in-order processor front end. At each rising clock edge it picks the next fetch address. The choices are the next sequential word, a taken conditional branch target or an unconditional jump target. The registered value drives the instruction-memory address directly.

The block does no decoding and no comparison. The decision signals arrive already resolved, and so do the raw instruction fields:

- a 16-bit branch displacement, counted in words;
- a 26-bit jump field, which is bits 25:0 of the instruction word.

An advance enable lets the pipeline stall fetch. A synchronous reset returns the counter to a configurable start address.

Top module: `fetch_pc_sequencer`

## Requirements
- R1: When `rst` is 1 at a rising edge, `pc_out` becomes RESET_ADDR with its two low bits forced to 0. This happens whatever `adv_en`, `take_branch` and `take_jump` are. The default RESET_ADDR is 0.
- R2: When `rst` is 0 and `adv_en` is 0 at a rising edge, `pc_out` keeps its value. `take_branch`, `take_jump` and both fields have no effect.
- R3: When `adv_en` is 1 and both `take_branch` and `take_jump` are 0, `pc_out` advances by 4.
- R4: When `adv_en` is 1, `take_branch` is 1 and `take_jump` is 0, the next `pc_out` is formed as follows. Sign-extend `br_disp` (bit 15 is the sign), shift it left by 2, and add it to `pc_out` + 4.
- R5: When `adv_en` is 1 and `take_jump` is 1, the next `pc_out` is built from three parts, most significant first:
  - bits 31:28 of (`pc_out` + 4);
  - `jmp_field` in bits 27:2;
  - zeros in bits 1:0.
- R6: A jump takes priority: `take_branch` is ignored whenever `take_jump` is 1.
- R7: All address arithmetic wraps modulo 2^32. 0xFFFFFFFC advances to 0x00000000. A negative displacement taken from address 0 lands at the top of the address space.
- R8: Outside reset, bits 1:0 of `pc_out` are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Load enable for the program counter |
| take_branch | input | 1 | Resolved branch-taken decision |
| take_jump | input | 1 | Unconditional jump select |
| br_disp | input | 16 | Signed branch displacement in words |
| jmp_field | input | 26 | Jump target field, instruction bits 25:0 |
| pc_out | output | 32 | Current program counter, fetch address |

## Verification
The hardest cases to reach from the ports are the two region and wrap boundaries. The first is a jump issued from 0x0FFFFFFC, where the upper nibble must come from the incremented counter and not from the current one. The second is sequential wrap past 0xFFFFFFFC.

Neither address can be reached by stepping, so the stimulus chains targets to get there:
- A jump with an all-ones field from region 0 lands at 0x0FFFFFFC. A sequential step then crosses into region 1, and a later jump confirms that the new nibble is used.
- From reset, a branch with displacement -2 reaches 0xFFFFFFFC. The next plain step must wrap to zero.

// File: rtl/fetch_pc_sequencer.sv
module fetch_pc_sequencer #(
  parameter int          PC_W       = 32,
  parameter int          DISP_W     = 16,
  parameter logic [31:0] RESET_ADDR = 32'h0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv_en,
  input  logic                 take_branch,
  input  logic                 take_jump,
  input  logic [DISP_W-1:0]    br_disp,
  input  logic [PC_W-7:0]      jmp_field,
  output logic [PC_W-1:0]      pc_out
);

  localparam int JUMP_W = PC_W - 6;
  localparam int EXT_W  = PC_W - DISP_W - 2;
  localparam logic [PC_W-1:0] START = {RESET_ADDR[PC_W-1:2], 2'b00};

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] seq_addr;
  logic [PC_W-1:0] br_offset;
  logic [PC_W-1:0] br_addr;
  logic [PC_W-1:0] jmp_addr;
  logic [PC_W-1:0] pc_d;

  assign seq_addr  = pc_q + PC_W'(4);
  assign br_offset = {{EXT_W{br_disp[DISP_W-1]}}, br_disp, 2'b00};
  assign br_addr   = seq_addr + br_offset;
  assign jmp_addr  = {seq_addr[PC_W-1:PC_W-4], jmp_field, 2'b00};

  always_comb begin
    if (take_jump)        pc_d = jmp_addr;
    else if (take_branch) pc_d = br_addr;
    else                  pc_d = seq_addr;
  end

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= START;
    else if (adv_en) pc_q <= pc_d;
  end

  assign pc_out = pc_q;

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> $stable(pc_out));

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !take_jump && !take_branch) |=> pc_out == $past(pc_out) + PC_W'(4));

  assert_branch_target_R4: assert property (@(posedge clk) disable iff (rst)
    (adv_en && take_branch && !take_jump) |=>
      pc_out == $past(pc_out) + PC_W'(4) + {{EXT_W{$past(br_disp[DISP_W-1])}}, $past(br_disp), 2'b00});

  assert_jump_field_R5: assert property (@(posedge clk) disable iff (rst)
    (adv_en && take_jump) |=> pc_out[PC_W-5:2] == $past(jmp_field));

  assert_jump_over_branch_R6: assert property (@(posedge clk) disable iff (rst)
    (adv_en && take_jump && take_branch) |=> pc_out[JUMP_W+1:0] == {$past(jmp_field), 2'b00});

  assert_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    pc_out[1:0] == 2'b00);

endmodule

// File: tb/fetch_pc_sequencer_test.sv
`timescale 1ns/100ps
module fetch_pc_sequencer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_en = 1'b0;
  logic        take_branch = 1'b0;
  logic        take_jump = 1'b0;
  logic [15:0] br_disp = '0;
  logic [25:0] jmp_field = '0;
  logic [31:0] pc_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_pc = 32'h0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  fetch_pc_sequencer uut (
    .clk(clk), .rst(rst), .adv_en(adv_en), .take_branch(take_branch),
    .take_jump(take_jump), .br_disp(br_disp), .jmp_field(jmp_field),
    .pc_out(pc_out)
  );

  task automatic step(input logic r, input logic en, input logic br, input logic jp,
                      input logic [15:0] d, input logic [25:0] f, input string tag);
    logic [31:0] nxt;
    logic [31:0] inc;
    @(negedge clk);
    rst = r; adv_en = en; take_branch = br; take_jump = jp;
    br_disp = d; jmp_field = f;
    inc = model_pc + 32'd4;
    if (r)        nxt = 32'h0;
    else if (!en) nxt = model_pc;
    else if (jp)  nxt = {inc[31:28], f, 2'b00};
    else if (br)  nxt = inc + {{14{d[15]}}, d, 2'b00};
    else          nxt = inc;
    model_pc = nxt;
    sb.push_back('{nxt, tag});
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (pc_out !== it.exp) begin
        errors++;
        $display("FAIL %s pc_out=%h expected=%h", it.tag, pc_out, it.exp);
      end
      if (!rst) begin
        checks++;
        if (pc_out[1:0] !== 2'b00) begin
          errors++;
          $display("FAIL R8 pc_out[1:0]=%b expected=00", pc_out[1:0]);
        end
      end
    end
  end

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(1, 0, 0, 0, 16'h0, 26'h0, "R1 reset");
    step(0, 1, 0, 0, 16'h0, 26'h0, "R3 seq");
    step(0, 1, 0, 0, 16'h0, 26'h0, "R3 seq");
    step(0, 0, 1, 1, 16'h0050, 26'h123, "R2 hold");
    step(0, 0, 1, 0, 16'h0050, 26'h0, "R2 hold");
    step(0, 1, 1, 0, 16'h0003, 26'h0, "R4 fwd branch");
    step(0, 1, 1, 0, 16'hFFFC, 26'h0, "R4 back branch");
    step(0, 1, 0, 1, 16'h0000, 26'h100, "R5 jump");
    step(0, 1, 1, 1, 16'h0040, 26'h0200, "R6 jump over branch");
    step(0, 1, 0, 1, 16'h0000, 26'h3FFFFFF, "R5 jump top");
    step(0, 1, 0, 0, 16'h0000, 26'h0, "R7 region cross");
    step(0, 1, 0, 1, 16'h0000, 26'h5, "R5 region nibble");
    step(1, 1, 1, 1, 16'h1234, 26'h55, "R1 reset priority");
    step(0, 1, 1, 0, 16'hFFFE, 26'h0, "R7 negative wrap");
    step(0, 1, 0, 0, 16'h0000, 26'h0, "R7 seq wrap");
    step(0, 1, 1, 0, 16'h7FFF, 26'h0, "R4 max disp");
    step(0, 1, 1, 0, 16'h8000, 26'h0, "R4 min disp");
    step(0, 0, 0, 0, 16'h0000, 26'h0, "R2 idle hold");
    step(1, 0, 0, 0, 16'h0000, 26'h0, "R1 reset again");
    step(0, 1, 0, 0, 16'h0000, 26'h0, "R3 after reset");
    @(negedge clk);
    adv_en = 1'b0; rst = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule